// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block is the interrupt side of a UART register file. It tracks two conditions reported by the serial datapath: a received character waiting to be read, and the transmit holding register becoming empty. It merges them into one level interrupt request and into an identification code that software reads to learn why the line is up. The CPU reaches it through a small byte-wide register port. Offset 1 holds the per-condition enables, offset 4 holds a master gate bit, and offset 2 returns the identification code. Offset 0 returns the received byte on a read and accepts a transmit byte on a write, and both accesses have side effects on the pending conditions.

Each condition is held by its own two-state machine. The receive tracker has states `RX_QUIET` and `RX_HOLDING`. A character arrival (`RX_QUIET -> RX_HOLDING`) moves it to holding, and a read of offset 0 returns it to quiet (`RX_HOLDING -> RX_QUIET`), unless another character arrives in that same cycle.

The transmit tracker has states `TX_QUIET` and `TX_PENDING`. It moves to pending (`TX_QUIET -> TX_PENDING`) on a rising edge of the empty input, or when its enable is switched on while the holding register is already empty. It returns to quiet (`TX_PENDING -> TX_QUIET`) when software reads the identification code while that code reports transmit-empty, or when software writes a transmit byte. The identification code always shows a waiting received character ahead of a transmit-empty indication.

Top module: `uif_top`

## Requirements
- R1: After reset the identification code (offset 2) reads 0x01, the enable register (offset 1) and the gate register (offset 4) read 0x00, and `irq` is low.
- R2: A one-cycle pulse on `rx_arrive` makes receive pending. With enable bit 0 set, offset 2 then reads 0x04.
- R3: Receive pending is cleared only by a read of offset 0, which returns `rx_byte`. Reads of offset 2 leave it set. An `rx_arrive` in the same cycle as the offset 0 read keeps it set.
- R4: A rising edge on `tx_empty` makes transmit-empty pending. With enable bit 1 set, offset 2 then reads 0x02.
- R5: A read of offset 2 that returns 0x02 clears transmit-empty pending. A read that returns 0x04 or 0x01 leaves it unchanged.
- R6: A write to offset 0 clears transmit-empty pending without any read of offset 2. The clear takes priority over a rising edge of `tx_empty` in the same cycle.
- R7: When both conditions are pending and enabled, offset 2 reads 0x04.
- R8: A write to offset 1 that changes bit 1 from 0 to 1 while `tx_empty` is high makes transmit-empty pending. The same write with `tx_empty` low does not.
- R9: `irq` is high exactly when bit 3 of the gate register is set and at least one enabled condition is pending. After the gate bit is written 0, `irq` stays low.
- R10: A pending condition whose enable bit is 0 does not appear in offset 2 and does not raise `irq`. Offset 1 reads back bits 1:0 as written, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register offset of the current access |
| rd_en | input | 1 | Read strobe; side effects apply at the next clock edge |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid in the cycle of `rd_en`, zero otherwise |
| rx_byte | input | DATA_W | Received byte from the datapath, returned at offset 0 |
| rx_arrive | input | 1 | One-cycle pulse: a character has been received |
| tx_empty | input | 1 | Level: transmit holding register is empty |
| irq | output | 1 | Level interrupt request to the interrupt controller |

## Verification
The bench goes after the transmit clear paths. It checks that a write of a transmit byte silently drops a pending empty indication. A design that only cleared on the identification read would leave `irq` stuck high. It also checks that reading the code while it shows 0x04 must not drop the hidden transmit indication, or that interrupt would be lost. Further cases cover a character arriving in the same cycle as the receive read, an empty edge coinciding with a transmit write, and turning the transmit enable on while already empty. Finally it checks that the gate bit masks `irq` while the code still reports the cause. A design that gated the code too, or that missed the enable-on case, would show 0x01 where 0x04 or 0x02 is expected.

// File: rtl/uif_pkg.sv
package uif_pkg;

    // Register offsets; software decodes the identification code values.
    localparam int OFS_DATA = 0;
    localparam int OFS_ENAB = 1;
    localparam int OFS_IDENT = 2;
    localparam int OFS_GATE = 4;

    // Bit positions inside the enable and gate registers.
    localparam int EN_RX_BIT = 0;
    localparam int EN_TX_BIT = 1;
    localparam int GATE_BIT = 3;
    localparam int ENAB_W = 2;

    // Identification codes.
    localparam int CODE_NONE = 1;
    localparam int CODE_TX = 2;
    localparam int CODE_RX = 4;

    typedef enum logic {
        RX_QUIET,
        RX_HOLDING
    } rx_state_t;

    typedef enum logic {
        TX_QUIET,
        TX_PENDING
    } tx_state_t;

endpackage

// File: rtl/uif_rx_track.sv
module uif_rx_track
    import uif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arrive,
    input  logic take,
    output logic pending
);

    rx_state_t state_q;
    rx_state_t state_d;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_QUIET: begin
                if (arrive) begin
                    state_d = RX_HOLDING;
                end
            end
            RX_HOLDING: begin
                // A fresh arrival in the read cycle keeps the condition alive.
                if (take && !arrive) begin
                    state_d = RX_QUIET;
                end
            end
            default: state_d = RX_QUIET;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            RX_HOLDING: pending = 1'b1;
            default:    pending = 1'b0;
        endcase
    end

endmodule

// File: rtl/uif_tx_track.sv
module uif_tx_track
    import uif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_empty,
    input  logic en_on,
    input  logic ack,
    input  logic load,
    output logic pending
);

    tx_state_t state_q;
    tx_state_t state_d;
    logic      empty_q;
    logic      empty_rise;
    logic      clear;

    // Edge detector on the empty level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty_q <= 1'b0;
        end else begin
            empty_q <= tx_empty;
        end
    end

    assign empty_rise = tx_empty && !empty_q;
    assign clear      = ack || load;

    // Next-state selection; a clear outranks any set in the same cycle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_QUIET: begin
                if (!clear && (empty_rise || en_on)) begin
                    state_d = TX_PENDING;
                end
            end
            TX_PENDING: begin
                if (clear) begin
                    state_d = TX_QUIET;
                end
            end
            default: state_d = TX_QUIET;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            TX_PENDING: pending = 1'b1;
            default:    pending = 1'b0;
        endcase
    end

endmodule

// File: rtl/uif_ctrl_regs.sv
module uif_ctrl_regs
    import uif_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enab_wr,
    input  logic                gate_wr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                tx_empty,
    output logic [ENAB_W-1:0]   enab,
    output logic [DATA_W-1:0]   gate_reg,
    output logic                tx_en_on
);

    logic [ENAB_W-1:0] enab_q;
    logic [DATA_W-1:0] gate_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enab_q <= '0;
        end else if (enab_wr) begin
            enab_q <= wr_data[ENAB_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else if (gate_wr) begin
            gate_q <= wr_data;
        end
    end

    // Transmit enable switching on while the holding register is empty.
    assign tx_en_on = enab_wr && wr_data[EN_TX_BIT] && !enab_q[EN_TX_BIT] && tx_empty;
    assign enab     = enab_q;
    assign gate_reg = gate_q;

endmodule

// File: rtl/uif_iir_encode.sv
module uif_iir_encode
    import uif_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              rx_vis,
    input  logic              tx_vis,
    output logic [DATA_W-1:0] code
);

    // Receive outranks transmit-empty.
    always_comb begin
        unique casez ({rx_vis, tx_vis})
            2'b1?:   code = DATA_W'(CODE_RX);
            2'b01:   code = DATA_W'(CODE_TX);
            default: code = DATA_W'(CODE_NONE);
        endcase
    end

endmodule

// File: rtl/uif_top.sv
module uif_top
    import uif_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_arrive,
    input  logic              tx_empty,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_ENAB  = ADDR_W'(OFS_ENAB);
    localparam logic [ADDR_W-1:0] A_IDENT = ADDR_W'(OFS_IDENT);
    localparam logic [ADDR_W-1:0] A_GATE  = ADDR_W'(OFS_GATE);
    localparam logic [DATA_W-1:0] C_TX    = DATA_W'(CODE_TX);

    logic              rx_pend;
    logic              tx_pend;
    logic              rx_vis;
    logic              tx_vis;
    logic [ENAB_W-1:0] enab;
    logic [DATA_W-1:0] gate_reg;
    logic [DATA_W-1:0] iir;
    logic              tx_en_on;
    logic              rx_take;
    logic              tx_ack;
    logic              tx_load;
    logic              enab_wr;
    logic              gate_wr;

    // Access decode.
    assign rx_take = rd_en && (addr == A_DATA);
    assign tx_load = wr_en && (addr == A_DATA);
    assign enab_wr = wr_en && (addr == A_ENAB);
    assign gate_wr = wr_en && (addr == A_GATE);
    assign tx_ack  = rd_en && (addr == A_IDENT) && (iir == C_TX);

    uif_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .enab_wr  (enab_wr),
        .gate_wr  (gate_wr),
        .wr_data  (wr_data),
        .tx_empty (tx_empty),
        .enab     (enab),
        .gate_reg (gate_reg),
        .tx_en_on (tx_en_on)
    );

    uif_rx_track u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .arrive  (rx_arrive),
        .take    (rx_take),
        .pending (rx_pend)
    );

    uif_tx_track u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_empty (tx_empty),
        .en_on    (tx_en_on),
        .ack      (tx_ack),
        .load     (tx_load),
        .pending  (tx_pend)
    );

    assign rx_vis = rx_pend && enab[EN_RX_BIT];
    assign tx_vis = tx_pend && enab[EN_TX_BIT];

    uif_iir_encode #(.DATA_W(DATA_W)) u_enc (
        .rx_vis (rx_vis),
        .tx_vis (tx_vis),
        .code   (iir)
    );

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (addr)
                A_DATA:  rd_data = rx_byte;
                A_ENAB:  rd_data = DATA_W'(enab);
                A_IDENT: rd_data = iir;
                A_GATE:  rd_data = gate_reg;
                default: rd_data = '0;
            endcase
        end
    end

    assign irq = gate_reg[GATE_BIT] && (rx_vis || tx_vis);

endmodule

// File: rtl/uif_check.sv
module uif_check
    import uif_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              rx_arrive,
    input logic              irq,
    input logic              rx_pend,
    input logic              tx_pend,
    input logic [ENAB_W-1:0] enab
);

    // R2: an arrival always leaves receive pending.
    a_r2_rx_set: assert property (@(posedge clk) disable iff (!rst_n)
        rx_arrive |=> rx_pend);

    // R3: without a data read, receive pending persists.
    a_r3_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pend && !(rd_en && addr == ADDR_W'(OFS_DATA))) |=> rx_pend);

    // R5: reading code 0x02 drops transmit-empty pending.
    a_r5_tx_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == ADDR_W'(OFS_IDENT) && rd_data == DATA_W'(CODE_TX))
        |=> !tx_pend);

    // R5: reading code 0x04 keeps transmit-empty pending.
    a_r5_tx_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == ADDR_W'(OFS_IDENT) && rd_data == DATA_W'(CODE_RX) && tx_pend)
        |=> tx_pend);

    // R6: a transmit write clears the indication.
    a_r6_load_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_DATA)) |=> !tx_pend);

    // R7: an enabled receive wins the identification read.
    a_r7_rx_first: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(OFS_IDENT) && rx_pend && enab[EN_RX_BIT])
        |-> rd_data == DATA_W'(CODE_RX));

    // R9: closing the gate silences the request line.
    a_r9_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_GATE) && !wr_data[GATE_BIT]) |=> !irq);

endmodule

bind uif_top uif_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .rx_arrive (rx_arrive),
    .irq       (irq),
    .rx_pend   (rx_pend),
    .tx_pend   (tx_pend),
    .enab      (enab)
);

// File: tb/test_uif_top.sv
module test_uif_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam logic [7:0] RXB = 8'hA5;
    localparam int NVEC = 41;

    // Vector: op[24:23] (0 idle, 1 read, 2 write), addr[22:20], wdata[19:12],
    // rx[11], txe[10], exp_rd[9:2], exp_irq[1], unused[0]
    typedef logic [24:0] vec_t;

    function automatic vec_t v(input int op, input int a, input int d,
                               input bit rx, input bit tx, input int erd, input bit eirq);
        return {2'(op), 3'(a), 8'(d), rx, tx, 8'(erd), eirq, 1'b0};
    endfunction

    localparam vec_t VECS [NVEC] = '{
        v(2,4,8'h08,0,0,8'h00,0),  // gate on
        v(2,1,8'h01,0,0,8'h00,0),  // rx enable
        v(1,2,0,0,0,8'h01,0),      // R1 idle code
        v(0,0,0,1,0,8'h00,0),      // R2 arrival
        v(1,2,0,0,0,8'h04,1),      // R2
        v(1,2,0,0,0,8'h04,1),      // R3 code read keeps rx
        v(1,0,0,0,0,8'hA5,1),      // R3 data read
        v(1,2,0,0,0,8'h01,0),      // R3 cleared
        v(0,0,0,0,1,8'h00,0),      // R4 empty edge, tx disabled
        v(1,2,0,0,1,8'h01,0),      // R10 hidden tx
        v(2,1,8'h03,0,1,8'h00,0),
        v(1,2,0,0,1,8'h02,1),      // R4 / R5 ack
        v(1,2,0,0,1,8'h01,0),      // R5 cleared
        v(0,0,0,0,0,8'h00,0),
        v(2,1,8'h01,0,0,8'h00,0),
        v(2,1,8'h03,0,0,8'h00,0),  // R8 enable while not empty
        v(1,2,0,0,0,8'h01,0),      // R8 no set
        v(0,0,0,0,1,8'h00,0),      // edge
        v(2,0,8'h55,0,1,8'h00,1),  // R6 transmit write
        v(1,2,0,0,1,8'h01,0),      // R6 cleared
        v(2,1,8'h01,0,1,8'h00,0),
        v(2,1,8'h03,0,1,8'h00,0),  // R8 enable while empty
        v(1,2,0,0,1,8'h02,1),      // R8
        v(0,0,0,0,0,8'h00,0),
        v(0,0,0,1,1,8'h00,0),      // both conditions
        v(1,2,0,0,1,8'h04,1),      // R7
        v(1,2,0,0,1,8'h04,1),      // R5 rx code keeps tx
        v(1,0,0,0,1,8'hA5,1),
        v(1,2,0,0,1,8'h02,1),      // R5 tx survived
        v(1,2,0,0,1,8'h01,0),
        v(0,0,0,1,1,8'h00,0),
        v(2,4,8'h00,0,1,8'h00,1),  // R9 close gate
        v(1,2,0,0,1,8'h04,0),      // R9 code still shown
        v(2,4,8'h08,0,1,8'h00,0),
        v(1,4,0,0,1,8'h08,1),      // R9 gate reads back
        v(1,1,0,0,1,8'h03,1),      // R10 readback
        v(2,1,8'hFC,0,1,8'h00,1),  // R10 disable all, upper bits dropped
        v(1,2,0,0,1,8'h01,0),      // R10
        v(1,1,0,0,1,8'h00,0),      // R10 upper zero
        v(2,1,8'h01,0,1,8'h00,0),
        v(1,0,0,0,1,8'hA5,1)
    };

    logic              clk;
    logic              rst_n;
    logic [ADDR_W-1:0] addr;
    logic              rd_en;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] rx_byte;
    logic              rx_arrive;
    logic              tx_empty;
    logic              irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    uif_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_uif_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .rx_byte   (rx_byte),
        .rx_arrive (rx_arrive),
        .tx_empty  (tx_empty),
        .irq       (irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // One bus cycle: drive after the falling edge, sample just before the rising edge.
    task automatic cyc(input int op, input int a, input int d, input bit rx, input bit tx,
                       input int erd, input bit eirq, input string tag);
        @(negedge clk);
        addr      = ADDR_W'(a);
        rd_en     = (op == 1);
        wr_en     = (op == 2);
        wr_data   = DATA_W'(d);
        rx_arrive = rx;
        tx_empty  = tx;
        #(CLK_PERIOD / 2 - 1);
        n_cmp++;
        if (rd_data !== DATA_W'(erd) || irq !== eirq) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                     tag, rd_data, irq, DATA_W'(erd), eirq);
        end
    endtask

    initial begin
        rst_n = 1'b0; addr = '0; rd_en = 0; wr_en = 0; wr_data = '0;
        rx_byte = RXB; rx_arrive = 0; tx_empty = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        cyc(1, 2, 0, 0, 0, 8'h01, 0, "R1 code");
        cyc(1, 1, 0, 0, 0, 8'h00, 0, "R1 enables");
        cyc(1, 4, 0, 0, 0, 8'h00, 0, "R1 gate");

        for (int i = 0; i < NVEC; i++) begin
            cyc(int'(VECS[i][24:23]), int'(VECS[i][22:20]), int'(VECS[i][19:12]),
                VECS[i][11], VECS[i][10], int'(VECS[i][9:2]), VECS[i][1],
                $sformatf("vector %0d", i));
        end

        // R3: arrival in the same cycle as the data read keeps receive pending.
        cyc(1, 0, 0, 1, 1, 8'hA5, 0, "R3 setup");
        cyc(1, 0, 0, 1, 1, 8'hA5, 1, "R3 read with arrival");
        cyc(1, 2, 0, 0, 1, 8'h04, 1, "R3 still pending");
        cyc(1, 0, 0, 0, 1, 8'hA5, 1, "R3 drain");
        cyc(1, 2, 0, 0, 1, 8'h01, 0, "R3 drained");

        // R6: transmit write wins over an empty edge in the same cycle.
        cyc(0, 0, 0, 0, 0, 8'h00, 0, "R6 low");
        cyc(2, 1, 8'h03, 0, 0, 8'h00, 0, "R6 enable");
        cyc(2, 0, 8'h11, 0, 1, 8'h00, 0, "R6 edge with write");
        cyc(1, 2, 0, 0, 1, 8'h01, 0, "R6 clear wins");

        // R1 again: reset mid-run with a condition pending.
        cyc(0, 0, 0, 1, 1, 8'h00, 0, "R1 pre");
        cyc(1, 2, 0, 0, 1, 8'h04, 1, "R1 pending before reset");
        @(negedge clk) rst_n = 1'b0; tx_empty = 0; rd_en = 0; wr_en = 0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        cyc(1, 2, 0, 0, 0, 8'h01, 0, "R1 code after reset");
        cyc(1, 1, 0, 0, 0, 8'h00, 0, "R1 enables after reset");
        cyc(1, 4, 0, 0, 0, 8'h00, 0, "R1 gate after reset");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule